// File: doc/BRIEF.md
# UART Receiver with Line Status

This block is the receive half of an asynchronous serial port. It oversamples the incoming serial line with a 16x tick enable and finds a falling edge that may be a start bit. It confirms the start bit at mid-bit, then takes each later bit at its centre. The bits are assembled least significant bit first into a shift register. When the stop bit is sampled, the finished character moves into a single holding register, where a CPU can read it.

Three status flags go with the holding register: data ready, overrun and parity error. Line settings choose a word length of 5 to 8 bits and one of five parity modes. Two read strobes drive the flags. One strobe stands for a read of the holding register and clears data ready. The other stands for a read of the status register and clears the two error flags. When a character completes while the holding register is still full, the held byte is kept and the new character is dropped.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `rx_data_o` is 0 and `data_ready_o`, `overrun_o` and `parity_err_o` are all 0.
- R2: A low pulse on the line that has ended before the mid-bit sample (8 ticks after the falling edge is seen) is rejected. No character is produced and no output changes.
- R3: Each data bit is sampled once, at the centre of its 16-tick bit time, and shifted in least significant bit first. The number of data bits is set by `word_len_i`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The unused upper bits of `rx_data_o` read as 0.
- R4: When a character completes and the holding register is empty, the character is loaded into `rx_data_o` and `data_ready_o` goes to 1. A one-cycle pulse on `rd_data_i` clears `data_ready_o` and leaves `rx_data_o` unchanged.
- R5: When a character completes while `data_ready_o` is 1 and `rd_data_i` is not asserted, `overrun_o` goes to 1 and `rx_data_o` keeps the earlier byte. The new character is discarded.
- R6: A pulse on `rd_status_i` clears `overrun_o` and `parity_err_o`. It does not change `data_ready_o` or `rx_data_o`.
- R7: The parity modes are set as follows. `par_en_i`=0 means no parity bit is expected. `par_en_i`=1 and `par_stick_i`=0 means odd parity when `par_even_i`=0 and even parity when `par_even_i`=1. `par_en_i`=1 and `par_stick_i`=1 means the parity bit must be 1 when `par_even_i`=0 and 0 when `par_even_i`=1.
- R8: A parity error is attached to the character that enters the holding register. `parity_err_o` rises in the same cycle as the load that sets `data_ready_o`. A character dropped by an overrun never sets `parity_err_o`.
- R9: If `rd_data_i` is asserted in the same cycle that a character completes, the new character is loaded, `data_ready_o` stays 1 and `overrun_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| tick_i | input | 1 | 16x oversampling enable, one cycle per tick |
| word_len_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_even_i | input | 1 | Even parity select, or stick value select |
| par_stick_i | input | 1 | Forced-parity select |
| rd_data_i | input | 1 | Holding register read strobe |
| rd_status_i | input | 1 | Status register read strobe |
| rx_data_o | output | DATA_W | Holding register contents |
| data_ready_o | output | 1 | A character is waiting |
| overrun_o | output | 1 | A character was lost to overrun |
| parity_err_o | output | 1 | The held character had bad parity |

## Verification
The contended case is a character that completes in the same cycle as a holding register read. The read frees the register, so the new byte must replace the old one, data ready must stay set and no overrun may be flagged. The bench counts oversampling ticks from the falling edge of the start bit to place the read strobe in the exact cycle of completion. It then checks the loaded byte and the flags against its own model. Random frames with occasional missed reads also cause completions to land on a full register, which is where overrun and parity error interact.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] ff;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else        ff <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = ff[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      tick_i,
   input  logic                      line_i,
   input  logic [$clog2(DATA_W)-1:0] last_idx_i,
   input  logic                      par_en_i,
   output logic                      done_o,
   output logic [DATA_W-1:0]         data_o,
   output logic                      par_bit_o
);

   localparam int CNT_W = $clog2(OVS);
   localparam int BIT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);

   rx_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  idx;
   logic [DATA_W-1:0] shreg;
   logic              par_q;
   logic              done_q;
   logic              at_full;

   assign at_full = (cnt == FULL_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         cnt    <= '0;
         idx    <= '0;
         shreg  <= '0;
         par_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (tick_i) begin
            case (st)
               RX_IDLE: begin
                  if (!line_i) begin
                     st    <= RX_START;
                     cnt   <= '0;
                     shreg <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == MID_CNT) begin
                     cnt <= '0;
                     idx <= '0;
                     st  <= line_i ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               RX_DATA: begin
                  if (at_full) begin
                     cnt        <= '0;
                     shreg[idx] <= line_i;
                     if (idx == last_idx_i) st  <= par_en_i ? RX_PAR : RX_STOP;
                     else                   idx <= idx + BIT_W'(1);
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               RX_PAR: begin
                  if (at_full) begin
                     cnt   <= '0;
                     par_q <= line_i;
                     st    <= RX_STOP;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               RX_STOP: begin
                  if (at_full) begin
                     cnt    <= '0;
                     done_q <= 1'b1;
                     st     <= RX_IDLE;
                  end else begin
                     cnt <= cnt + CNT_W'(1);
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   assign done_o    = done_q;
   assign data_o    = shreg;
   assign par_bit_o = par_q;

endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              par_bit_i,
   input  logic              par_en_i,
   input  logic              par_even_i,
   input  logic              par_stick_i,
   output logic              bad_o
);

   logic want;

   always_comb begin
      if (par_stick_i) want = ~par_even_i;
      else if (par_even_i) want = ^data_i;
      else want = ~(^data_i);
      bad_o = par_en_i && (par_bit_i != want);
   end

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              bad_i,
   input  logic              rd_data_i,
   input  logic              rd_status_i,
   output logic [DATA_W-1:0] hold_o,
   output logic              ready_o,
   output logic              overrun_o,
   output logic              perr_o
);

   logic accept;

   assign accept = done_i && (!ready_o || rd_data_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_o    <= '0;
         ready_o   <= 1'b0;
         overrun_o <= 1'b0;
         perr_o    <= 1'b0;
      end else begin
         if (accept) begin
            hold_o  <= data_i;
            ready_o <= 1'b1;
         end else if (rd_data_i) begin
            ready_o <= 1'b0;
         end

         if (done_i && !accept) overrun_o <= 1'b1;
         else if (rd_status_i)  overrun_o <= 1'b0;

         if (accept && bad_i)  perr_o <= 1'b1;
         else if (rd_status_i) perr_o <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
   parameter int DATA_W      = 8,
   parameter int MIN_W       = 5,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick_i,
   input  logic [1:0]        word_len_i,
   input  logic              par_en_i,
   input  logic              par_even_i,
   input  logic              par_stick_i,
   input  logic              rd_data_i,
   input  logic              rd_status_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              data_ready_o,
   output logic              overrun_o,
   output logic              parity_err_o
);

   localparam int BIT_W = $clog2(DATA_W);

   generate
      if (DATA_W != MIN_W + 3) begin : g_bad_width
         $error("DATA_W must equal MIN_W + 3 for a two-bit length field");
      end
      if (OVS < 4 || (OVS % 2) != 0 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("OVS must be an even power of two, at least 4");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              line_s;
   logic [BIT_W-1:0]  last_idx;
   logic              char_done;
   logic [DATA_W-1:0] shift_data;
   logic              par_bit;
   logic              par_bad;

   assign last_idx = BIT_W'(MIN_W - 1) + BIT_W'(word_len_i);

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (line_s)
   );

   uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .line_i     (line_s),
      .last_idx_i (last_idx),
      .par_en_i   (par_en_i),
      .done_o     (char_done),
      .data_o     (shift_data),
      .par_bit_o  (par_bit)
   );

   uart_rx_parity #(.DATA_W(DATA_W)) u_parity (
      .data_i      (shift_data),
      .par_bit_i   (par_bit),
      .par_en_i    (par_en_i),
      .par_even_i  (par_even_i),
      .par_stick_i (par_stick_i),
      .bad_o       (par_bad)
   );

   uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (char_done),
      .data_i      (shift_data),
      .bad_i       (par_bad),
      .rd_data_i   (rd_data_i),
      .rd_status_i (rd_status_i),
      .hold_o      (rx_data_o),
      .ready_o     (data_ready_o),
      .overrun_o   (overrun_o),
      .perr_o      (parity_err_o)
   );

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              char_done,
   input logic              rd_data_i,
   input logic              rd_status_i,
   input logic [DATA_W-1:0] rx_data_o,
   input logic              data_ready_o,
   input logic              overrun_o,
   input logic              parity_err_o
);

   // R4
   read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_i && !char_done) |=> !data_ready_o);

   // R4
   ready_rise_from_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready_o) |-> $past(char_done));

   // R5
   overrun_keeps_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && data_ready_o && !rd_data_i) |=> (overrun_o && $stable(rx_data_o)));

   // R6
   status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_status_i && !char_done) |=> (!overrun_o && !parity_err_o));

   // R8
   perr_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(parity_err_o) |-> ($past(char_done) && data_ready_o));

   // R3
   data_moves_on_char_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_data_o) |-> $past(char_done));

   // R9
   read_and_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (char_done && rd_data_i && !overrun_o) |=> (data_ready_o && !overrun_o));

endmodule

bind uart_rx_status uart_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .char_done    (char_done),
   .rd_data_i    (rd_data_i),
   .rd_status_i  (rd_status_i),
   .rx_data_o    (rx_data_o),
   .data_ready_o (data_ready_o),
   .overrun_o    (overrun_o),
   .parity_err_o (parity_err_o)
);

// File: tb/uart_rx_status_bench.sv
`timescale 1ns/1ps
module uart_rx_status_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx = 1'b1;
   logic       tick = 1'b0;
   logic [1:0] wl = 2'd3;
   logic       pen = 1'b0;
   logic       peven = 1'b0;
   logic       pstick = 1'b0;
   logic       rd_data = 1'b0;
   logic       rd_status = 1'b0;
   logic [7:0] dout;
   logic       dr, ovr, perr;

   int checks = 0;
   int fails = 0;
   int div = 1;
   int tcnt = 0;
   bit finished = 1'b0;

   logic [7:0] m_data = 8'h00;
   bit m_dr = 1'b0, m_ovr = 1'b0, m_pe = 1'b0;

   always #4 clk = ~clk;

   always @(negedge clk) begin
      if (tcnt >= div - 1) begin
         tick = 1'b1;
         tcnt = 0;
      end else begin
         tick = 1'b0;
         tcnt = tcnt + 1;
      end
   end

   uart_rx_status u_uart_rx_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .rx_i         (rx),
      .tick_i       (tick),
      .word_len_i   (wl),
      .par_en_i     (pen),
      .par_even_i   (peven),
      .par_stick_i  (pstick),
      .rd_data_i    (rd_data),
      .rd_status_i  (rd_status),
      .rx_data_o    (dout),
      .data_ready_o (dr),
      .overrun_o    (ovr),
      .parity_err_o (perr)
   );

   function automatic logic par_bit(logic [7:0] d, logic [1:0] w, bit ev, bit st);
      logic [7:0] m;
      m = d & 8'((9'd1 << (5 + w)) - 9'd1);
      if (st) return ~ev;
      return ev ? ^m : ~(^m);
   endfunction

   task automatic chk(string req, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic check_all(string req);
      chk(req, "rx_data", int'(dout), int'(m_data));
      chk(req, "data_ready", int'(dr), int'(m_dr));
      chk(req, "overrun", int'(ovr), int'(m_ovr));
      chk(req, "parity_err", int'(perr), int'(m_pe));
   endtask

   task automatic send_frame(logic [7:0] d, bit corrupt, bit coll);
      int n, s;
      n = 5 + int'(wl);
      s = 1 + n + (pen ? 1 : 0);
      fork
         begin
            @(negedge clk);
            rx = 1'b0;
            repeat (16 * div) @(negedge clk);
            for (int i = 0; i < n; i++) begin
               rx = d[i];
               repeat (16 * div) @(negedge clk);
            end
            if (pen) begin
               rx = par_bit(d, wl, peven, pstick) ^ corrupt;
               repeat (16 * div) @(negedge clk);
            end
            rx = 1'b1;
            repeat (16 * div) @(negedge clk);
         end
         begin
            if (coll) begin
               repeat (12 + 16 * s) @(negedge clk);
               rd_data = 1'b1;
               @(negedge clk);
               rd_data = 1'b0;
            end
         end
      join
      repeat (3) @(negedge clk);
   endtask

   task automatic run_frame(string req, logic [7:0] d, bit corrupt, bit coll);
      bit bad;
      bad = pen && corrupt;
      send_frame(d, corrupt, coll);
      if (!m_dr || coll) begin
         m_data = d & 8'((9'd1 << (5 + wl)) - 9'd1);
         m_dr = 1'b1;
         if (bad) m_pe = 1'b1;
      end else begin
         m_ovr = 1'b1;
      end
      check_all(req);
   endtask

   task automatic do_rd_data(string req);
      @(negedge clk); rd_data = 1'b1;
      @(negedge clk); rd_data = 1'b0;
      m_dr = 1'b0;
      @(negedge clk);
      check_all(req);
   endtask

   task automatic do_rd_status(string req);
      @(negedge clk); rd_status = 1'b1;
      @(negedge clk); rd_status = 1'b0;
      m_ovr = 1'b0;
      m_pe = 1'b0;
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      check_all("R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_all("R1");

      // R3 / R4: eight bits, no parity
      wl = 2'd3; pen = 1'b0;
      run_frame("R3", 8'hA5, 1'b0, 1'b0);
      do_rd_data("R4");

      // R2: short low pulse is not a start bit
      @(negedge clk); rx = 1'b0;
      repeat (5) @(negedge clk);
      rx = 1'b1;
      repeat (60) @(negedge clk);
      check_all("R2");

      // R3: five-bit word, upper bits zero
      wl = 2'd0;
      run_frame("R3", 8'hF5, 1'b0, 1'b0);

      // R5 / R8: completion on full register, dropped char carries bad parity
      wl = 2'd2; pen = 1'b1; peven = 1'b0; pstick = 1'b0;
      run_frame("R5", 8'h3C, 1'b1, 1'b0);
      run_frame("R8", 8'h11, 1'b1, 1'b0);
      do_rd_status("R6");
      do_rd_data("R4");

      // R7 / R8: every parity mode, good and bad
      wl = 2'd3;
      for (int mode = 0; mode < 4; mode++) begin
         for (int c = 0; c < 2; c++) begin
            pen = 1'b1;
            peven = mode[0];
            pstick = mode[1];
            run_frame((c != 0) ? "R8" : "R7", 8'(8'h5B + 8'(mode * 37)), c[0], 1'b0);
            do_rd_data("R4");
            do_rd_status("R6");
         end
      end

      // R9: read strobe in the cycle the next character completes
      pen = 1'b0; wl = 2'd3; div = 1;
      run_frame("R9", 8'h81, 1'b0, 1'b0);
      run_frame("R9", 8'h7E, 1'b0, 1'b1);
      do_rd_data("R4");

      // random frames
      for (int k = 0; k < 40; k++) begin
         div = ($urandom_range(0, 3) == 0) ? 2 : 1;
         wl = 2'($urandom_range(0, 3));
         pen = 1'($urandom_range(0, 1));
         peven = 1'($urandom_range(0, 1));
         pstick = 1'($urandom_range(0, 1));
         run_frame(pen ? "R7" : "R3", 8'($urandom_range(0, 255)),
                   ($urandom_range(0, 3) == 0), 1'b0);
         if ($urandom_range(0, 2) != 0) do_rd_data("R4");
         if ($urandom_range(0, 2) == 0) do_rd_status("R6");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule